// File: doc/BRIEF.md
# Binary64 to Unsigned 32-bit Truncating Converter

This unit takes one IEEE-754 double-precision word and produces a 32-bit unsigned integer. It always rounds toward zero, whatever rounding setting the rest of the machine uses. Alongside the integer it reports two status flags: `invalid`, for inputs that have no 32-bit unsigned result, and `inexact`, for valid conversions that dropped nonzero fraction bits. When `invalid` is raised, the integer output is replaced by all ones.

Operands are presented with a valid strobe. Results appear after one register stage. Each lane of a vector conversion datapath instantiates one copy. Masking and the merging of lanes are left to the surrounding datapath.

Top module: `dtu_trunc_conv`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock. While `rst_n` is low, `out_valid`, `out_value`, `out_invalid` and `out_inexact` are all 0.
- R2: For a positive input x with 1.0 <= x < 2^32, `out_value` equals floor(x) and `out_invalid` is 0.
- R3: Whenever `out_invalid` is 1, `out_value` is 0xFFFFFFFF and `out_inexact` is 0.
- R4: A NaN input, or an input of +infinity or -infinity (exponent field bits [62:52] all ones), sets `out_invalid`.
- R5: Inputs of -1.0 or less set `out_invalid`. Inputs strictly between -1.0 and 0 give `out_value` 0 and `out_inexact` 1, with `out_invalid` 0.
- R6: Inputs of 2^32 or more set `out_invalid`. Inputs in [2^32-1, 2^32) give 0xFFFFFFFF with `out_invalid` 0.
- R7: Zeros of either sign and denormals (exponent field 0) give `out_value` 0 with `out_invalid` 0. `out_inexact` is 1 exactly when the mantissa field is nonzero.
- R8: On a valid conversion, `out_inexact` is 1 exactly when the input is not a whole number.
- R9: A cycle with `in_valid` low leaves `out_value`, `out_invalid` and `out_inexact` unchanged on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_bits | input | 64 | Binary64 operand: sign [63], exponent [62:52], mantissa [51:0] |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_value | output | 32 | Truncated unsigned integer, or all ones when invalid |
| out_invalid | output | 1 | Operand not representable as a 32-bit unsigned integer |
| out_inexact | output | 1 | Nonzero fraction bits were discarded |

## Verification
A wrong class decision shows at the ports on the very next cycle. An operand sent to the wrong side of a range boundary flips `out_invalid` and changes the integer to or from all ones. A wrong shift amount or lost-bit mask leaves the class correct, but it corrupts the integer or the `inexact` flag. That is why the operands cluster around powers of two, the 2^32-1 ceiling and the -1.0 floor. Every clock is compared against a model that uses real arithmetic. A fault is therefore reported on the cycle it first reaches the outputs.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int FP_W  = 64;
  localparam int EXP_W = 11;
  localparam int MAN_W = 52;
  localparam int INT_W = 32;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int POW_W = $clog2(INT_W);
  localparam int SH_W  = $clog2(MAN_W + 1);

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;
  } fp_t;

  // Operand classes as seen by the output stage
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,  // exponent field zero: zero or denormal
    CLS_FRAC = 2'd1,  // 0 < |x| < 1, normal
    CLS_INT  = 2'd2,  // 1 <= x < 2^INT_W, positive
    CLS_BAD  = 2'd3   // unrepresentable
  } cls_e;

  // Right-shift distance that moves the binary point to bit 0
  function automatic logic [SH_W-1:0] shift_for(input logic [POW_W-1:0] pw);
    return SH_W'(MAN_W) - SH_W'(pw);
  endfunction

  // Mask covering the bits that a shift of sh discards
  function automatic logic [MAN_W:0] lost_mask(input logic [SH_W-1:0] sh);
    return ~({(MAN_W+1){1'b1}} << sh);
  endfunction
endpackage

// File: rtl/dtu_unpack.sv
module dtu_unpack
  import dtu_pkg::*;
(
  input  fp_t              op,
  output cls_e             cls,
  output logic [POW_W-1:0] pw,
  output logic             tiny_nz,
  output logic             is_special
);
  logic exp_max, exp_zero, below_one, too_big;

  always_comb begin
    exp_max    = (op.expo == '1);
    exp_zero   = (op.expo == '0);
    below_one  = (int'(op.expo) < BIAS);
    too_big    = (int'(op.expo) >= BIAS + INT_W);
    is_special = exp_max;
    tiny_nz    = exp_zero && (op.mant != '0);
    pw         = POW_W'(int'(op.expo) - BIAS);
    if (exp_max)              cls = CLS_BAD;
    else if (exp_zero)        cls = CLS_ZERO;
    else if (below_one)       cls = CLS_FRAC;
    else if (op.sign)         cls = CLS_BAD;
    else if (too_big)         cls = CLS_BAD;
    else                      cls = CLS_INT;
  end
endmodule

// File: rtl/dtu_align.sv
module dtu_align
  import dtu_pkg::*;
(
  input  logic [MAN_W-1:0] mant,
  input  logic [POW_W-1:0] pw,
  output logic [INT_W-1:0] int_val,
  output logic             lost
);
  logic [MAN_W:0]  sig;
  logic [MAN_W:0]  kept;
  logic [SH_W-1:0] sh;

  always_comb begin
    sig     = {1'b1, mant};
    sh      = shift_for(pw);
    kept    = sig >> sh;
    lost    = |(sig & lost_mask(sh));
    int_val = kept[INT_W-1:0];
  end
endmodule

// File: rtl/dtu_trunc_conv.sv
module dtu_trunc_conv
  import dtu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [FP_W-1:0]  in_bits,
  output logic             out_valid,
  output logic [INT_W-1:0] out_value,
  output logic             out_invalid,
  output logic             out_inexact
);
  fp_t              op;
  cls_e             cls;
  logic [POW_W-1:0] pw;
  logic             tiny_nz, is_special, lost;
  logic [INT_W-1:0] int_val;
  logic [INT_W-1:0] res_w;
  logic             inv_w, inx_w;
  logic             neg_large;

  assign op = fp_t'(in_bits);

  dtu_unpack u_unpack (
    .op(op), .cls(cls), .pw(pw), .tiny_nz(tiny_nz), .is_special(is_special)
  );

  dtu_align u_align (
    .mant(op.mant), .pw(pw), .int_val(int_val), .lost(lost)
  );

  // Named event for assertions: negative operand of magnitude >= 1
  assign neg_large = op.sign && (int'(op.expo) >= BIAS);

  always_comb begin
    unique case (cls)
      CLS_BAD:  begin res_w = '1;      inv_w = 1'b1; inx_w = 1'b0;    end
      CLS_INT:  begin res_w = int_val; inv_w = 1'b0; inx_w = lost;    end
      CLS_FRAC: begin res_w = '0;      inv_w = 1'b0; inx_w = 1'b1;    end
      default:  begin res_w = '0;      inv_w = 1'b0; inx_w = tiny_nz; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_value   <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_value   <= res_w;
        out_invalid <= inv_w;
        out_inexact <= inx_w;
      end
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_INVALID_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> (out_value == '1 && !out_inexact)); // R3
  AST_SPECIAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_special) |=> out_invalid); // R4
  AST_NEG_LARGE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && neg_large) |=> out_invalid); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_valid) |=> $stable(out_value)); // R9
endmodule

// File: tb/dtu_trunc_conv_tb.sv
module dtu_trunc_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_bits = '0;
  logic        out_valid;
  logic [31:0] out_value;
  logic        out_invalid, out_inexact;

  int checks = 0;
  int failures = 0;

  logic        e_valid = 1'b0;
  logic [31:0] e_value = '0;
  logic        e_inv = 1'b0, e_inx = 1'b0;
  string       e_tag = "R1";

  always #10 clk = ~clk;

  dtu_trunc_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .out_valid(out_valid), .out_value(out_value),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  task automatic compare();
    checks++;
    if (out_valid !== e_valid || out_value !== e_value ||
        out_invalid !== e_inv || out_inexact !== e_inx) begin
      failures++;
      $display("FAIL %s in=%h actual v=%b val=%h inv=%b inx=%b expected v=%b val=%h inv=%b inx=%b",
               e_tag, in_bits, out_valid, out_value, out_invalid, out_inexact,
               e_valid, e_value, e_inv, e_inx);
    end
  endtask

  // Reference built from real arithmetic
  task automatic model(input logic [63:0] b);
    real r, t;
    r = $bitstoreal(b);
    if (b[62:52] == '1) begin
      e_value = '1; e_inv = 1'b1; e_inx = 1'b0; e_tag = "R4";
    end else if (r <= -1.0) begin
      e_value = '1; e_inv = 1'b1; e_inx = 1'b0; e_tag = "R5";
    end else if (r >= 4294967296.0) begin
      e_value = '1; e_inv = 1'b1; e_inx = 1'b0; e_tag = "R6";
    end else if (r < 0.0) begin
      e_value = '0; e_inv = 1'b0; e_inx = 1'b1;
      e_tag = (b[62:52] == '0) ? "R7" : "R5";
    end else begin
      t = $floor(r);
      e_value = 32'(longint'(t));
      e_inv = 1'b0;
      e_inx = (t != r);
      if (b[62:52] == '0)          e_tag = "R7";
      else if (r >= 4294967295.0)  e_tag = "R6";
      else if (e_inx)              e_tag = "R8";
      else                         e_tag = "R2";
    end
  endtask

  task automatic step(input logic v, input logic [63:0] b);
    @(negedge clk);
    compare();
    in_valid = v;
    in_bits  = b;
    e_valid  = v;
    if (v) model(b);
    else   e_tag = "R9";
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    e_tag = "R1";
    compare();              // reset state, R1
    rst_n = 1'b1;
    step(1'b1, 64'h0000000000000000);   // +0, R7
    step(1'b1, 64'h8000000000000000);   // -0, R7
    step(1'b1, 64'h0000000000000001);   // denormal, R7
    step(1'b1, 64'h3FF0000000000000);   // 1.0, R2
    step(1'b1, 64'h3FF8000000000000);   // 1.5, R8
    step(1'b1, 64'h4004000000000000);   // 2.5
    step(1'b1, 64'h405EF00000000000);   // 123.75
    step(1'b1, 64'h3FEFFFFFFFFFFFFF);   // just below 1
    step(1'b1, 64'h0010000000000000);   // smallest normal
    step(1'b1, 64'hBFE0000000000000);   // -0.5, R5
    step(1'b1, 64'hBFF0000000000000);   // -1.0, R5
    step(1'b1, 64'hC000000000000000);   // -2.0
    step(1'b1, 64'h41E0000000000000);   // 2^31
    step(1'b1, 64'h41EFFFFFFFE00000);   // 2^32-1, R6
    step(1'b1, 64'h41EFFFFFFFF00000);   // 2^32-0.5, R6
    step(1'b1, 64'h41F0000000000000);   // 2^32, R6
    step(1'b1, 64'h7FF0000000000000);   // +inf, R4
    step(1'b1, 64'hFFF0000000000000);   // -inf
    step(1'b1, 64'h7FF8000000000000);   // NaN
    step(1'b1, 64'h4010000000000001);   // 4 plus one ulp
    step(1'b0, 64'hBFF0000000000000);   // idle, R9
    step(1'b0, 64'h7FF0000000000000);   // idle, R9
    for (int i = 0; i < 600; i++) begin
      logic [63:0] b;
      b = {$urandom, $urandom};
      if (i % 3 != 0) b[62:52] = 11'(1000 + ($urandom % 70));
      step(($urandom % 5) != 0, b);
    end
    step(1'b0, '0);
    step(1'b0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule